// File: doc/BRIEF.md
# Prescaled Countdown Interrupt Timer

This block counts down from a programmed start value and raises a one-clock interrupt request, tagged with a programmed vector, when the count runs out. A free-running tick enable from the surrounding clock domain is first divided by a power of two chosen through a small configuration field. Each divided tick then decrements the count. The timer runs in one of two modes. In single-shot mode it stops at zero after firing once. In repeating mode it reloads the start value and fires once per period.

Software programs the timer through three write strobes that share one data bus: the start value, the divider field and a control word. The control word holds the vector, a suppress bit and a mode bit. The present count is always visible on an output port. It keeps moving while the interrupt is suppressed, so the timer can be polled with no interrupt at all.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the count reads 0, no interrupt is raised, the control word has its suppress bit (bit 16) set, and the divider is 1, so each tick enable decrements the count.
- R2: A divider write keeps data bits 3, 1 and 0. These form a 3-bit code with bit 3 as its MSB and bits 1:0 below it. The shift is that code plus one, modulo 8. One divided tick then occurs for every 2^shift tick enables. Example values: 0xB and 0xF give /1, 0x0 gives /2, 0x1 gives /4, 0x3 gives /16, 0x8 gives /32 and 0xA gives /128. A divider write restarts the divider phase.
- R3: A start-value write puts that value on the count output after the next clock edge. It restarts the divider phase and re-arms single-shot firing. It takes precedence over a divided tick and over an expiry that fall in the same cycle.
- R4: In single-shot mode (control bit 17 clear) each divided tick lowers the count by one down to 0, where it stays. Exactly one expiry occurs, on the divided tick that finds the count at 0, which is start-value-plus-one divided ticks after the start write.
- R5: In repeating mode (control bit 17 set) the divided tick that finds the count at 0 reloads the start value and causes an expiry. Expiries therefore repeat every start-value-plus-one divided ticks.
- R6: With a start value of 0 no expiry occurs in either mode.
- R7: While control bit 16 is set, expiries raise no interrupt, but the count and the reload behave exactly as when it is clear.
- R8: Each expiry raises the interrupt output for exactly one clock. While the interrupt is high, the vector output carries control bits 7:0.
- R9: A control-word write changes neither the count nor the divider phase.
- R10: In a cycle with the tick enable low and no start-value write, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tick enable fed to the divider |
| wr_start | input | 1 | Write strobe for the start value |
| wr_div | input | 1 | Write strobe for the divider field (bits 3:0) |
| wr_ctl | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Shared write data |
| cur_count | output | 32 | Present count |
| irq_pulse | output | 1 | One-clock interrupt request on expiry |
| irq_vector | output | 8 | Vector that goes with the interrupt |

## Verification
A start-value write can land in the same cycle as the divided tick that would expire a repeating timer whose count sits at 0. The bench provokes this by running a /1 repeating timer down to zero and then asserting the write together with the tick enable on the following cycle. It judges the outcome by requiring that no interrupt appears, that the count reads the new value, and that the next tick lowers that value by one.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int SHIFT_W  = 3;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  // divider field -> prescale shift (bits 3,1,0 rearranged, plus one, wraps)
  function automatic logic [SHIFT_W-1:0] div_field_to_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction

  // compare value of the phase counter for a given shift
  function automatic logic [(1<<SHIFT_W)-2:0] phase_limit(input logic [SHIFT_W-1:0] sh);
    return ~({((1<<SHIFT_W)-1){1'b1}} << sh);
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               restart,
  input  logic               ld_shift,
  input  logic [SHIFT_W-1:0] new_shift,
  output logic               ptick
);
  localparam int PH_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shift_q;
  logic [PH_W-1:0]    phase_q;
  logic [PH_W-1:0]    lim;

  assign lim   = phase_limit(shift_q);
  assign ptick = tick_en && (phase_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      phase_q <= '0;
    end else begin
      if (ld_shift) shift_q <= new_shift;
      if (restart)      phase_q <= '0;
      else if (tick_en) phase_q <= ptick ? '0 : phase_q + PH_W'(1);
    end
  end

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ld_shift) |=> (ptick == (tick_en && shift_q == '0))); // R3
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] start_q;
  logic             spent_q;
  logic             at_zero;

  assign at_zero = (cur_q == '0);
  assign expire  = ptick && !load && at_zero && (start_q != '0) &&
                   (periodic || !spent_q);
  assign cur     = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      start_q <= '0;
      spent_q <= 1'b0;
    end else if (load) begin
      cur_q   <= load_val;
      start_q <= load_val;
      spent_q <= 1'b0;
    end else if (ptick) begin
      if (!at_zero)                         cur_q <= cur_q - CNT_W'(1);
      else if (periodic && start_q != '0)   cur_q <= start_q;
      if (expire && !periodic)              spent_q <= 1'b1;
    end
  end

  AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_val))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptick && !load) |=> $stable(cur_q)); // R10
  AST_ONESHOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && at_zero && !load) |=> (cur_q == '0)); // R4
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur_q == start_q)); // R5
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !expire); // R6
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              masked,
  output logic              periodic,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam logic [DATA_W-1:0] CTL_RST = DATA_W'(1) << MASK_BIT;

  logic [DATA_W-1:0] ctl_q;
  logic              pulse_q;
  logic [VEC_W-1:0]  vec_q;

  assign masked     = ctl_q[MASK_BIT];
  assign periodic   = ctl_q[MODE_BIT];
  assign irq_pulse  = pulse_q;
  assign irq_vector = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RST;
      pulse_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data;
      pulse_q <= expire && !masked;
      if (expire) vec_q <= ctl_q[VEC_W-1:0];
    end
  end

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(masked)); // R7
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_ctl) |=> (irq_vector == ctl_q[VEC_W-1:0])); // R8
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_start,
  input  logic             wr_div,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  logic               ptick;
  logic               expire;
  logic               masked;
  logic               periodic;
  logic [SHIFT_W-1:0] new_shift;

  assign new_shift = div_field_to_shift(wr_data[3:0]);

  cdt_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .restart   (wr_start || wr_div),
    .ld_shift  (wr_div),
    .new_shift (new_shift),
    .ptick     (ptick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptick    (ptick),
    .load     (wr_start),
    .load_val (wr_data),
    .periodic (periodic),
    .cur      (cur_count),
    .expire   (expire)
  );

  cdt_ctrl #(.DATA_W(CNT_W), .VEC_W(VEC_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_ctl),
    .wr_data    (wr_data),
    .expire     (expire),
    .masked     (masked),
    .periodic   (periodic),
    .irq_pulse  (irq_pulse),
    .irq_vector (irq_vector)
  );

  AST_NO_FIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !irq_pulse); // R3
endmodule

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int WATCHDOG = 150000;

  localparam int V_DIV [NV] = '{'hB, 'h0, 'h1, 'h8, 'hB, 'hB, 'hB, 'h3, 'hF, 'hA};
  localparam int V_CTL [NV] = '{'h20040, 'h00021, 'h00022, 'h20033, 'h30055,
                               'h20066, 'h00077, 'h00088, 'h20099, 'h000AA};
  localparam int V_N   [NV] = '{3, 5, 10, 2, 4, 0, 0, 1, 1, 1};
  localparam int V_K   [NV] = '{10, 20, 20, 200, 25, 10, 10, 40, 7, 300};
  localparam int V_CNT [NV] = '{1, 0, 5, 2, 4, 0, 0, 0, 0, 0};
  localparam int V_PUL [NV] = '{2, 1, 0, 2, 0, 0, 0, 1, 3, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_start = 1'b0;
  logic        wr_div = 1'b0;
  logic        wr_ctl = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_start(wr_start),
    .wr_div(wr_div), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // kind: 0 start, 1 divider, 2 control
  task automatic wr(input int kind, input logic [31:0] d);
    wr_data  = d;
    wr_start = (kind == 0);
    wr_div   = (kind == 1);
    wr_ctl   = (kind == 2);
    @(negedge clk);
    wr_start = 1'b0;
    wr_div   = 1'b0;
    wr_ctl   = 1'b0;
  endtask

  task automatic run(input int k, input logic [7:0] vec, output int pulses);
    bit prev;
    prev = 1'b0;
    pulses = 0;
    tick_en = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (irq_pulse) begin
        pulses++;
        check("R8 vector", irq_vector, vec);
        if (prev) check("R8 width", 2, 1);
      end
      prev = irq_pulse;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, divide by 1, suppressed interrupt
    check("R1 count", cur_count, 0);
    check("R1 irq", irq_pulse, 0);
    wr(0, 3);
    run(2, 8'h00, p);
    check("R1 div1 count", cur_count, 1);
    run(5, 8'h00, p);
    check("R1 count floor", cur_count, 0);
    check("R1 masked pulses", p, 0);

    // table: R2 divider, R4 single-shot, R5 repeating, R6 zero start, R7 suppress
    for (int v = 0; v < NV; v++) begin
      wr(1, V_DIV[v]);
      wr(2, V_CTL[v]);
      wr(0, V_N[v]);
      run(V_K[v], V_CTL[v][7:0], p);
      check($sformatf("R2 R4 R5 R6 R7 vec%0d count", v), cur_count, V_CNT[v]);
      check($sformatf("R2 R4 R5 R6 R7 vec%0d pulses", v), p, V_PUL[v]);
    end

    // R3: start write collides with an expiring divided tick
    wr(1, 'hB);
    wr(2, 'h20011);
    wr(0, 2);
    run(2, 8'h11, p);
    check("R3 pre count", cur_count, 0);
    tick_en  = 1'b1;
    wr_start = 1'b1;
    wr_data  = 5;
    @(negedge clk);
    tick_en  = 1'b0;
    wr_start = 1'b0;
    check("R3 no irq", irq_pulse, 0);
    check("R3 loaded", cur_count, 5);
    run(1, 8'h11, p);
    check("R3 next tick", cur_count, 4);

    // R9: control write keeps count and divider phase
    wr(1, 'h1);
    wr(2, 'h00010);
    wr(0, 10);
    run(2, 8'h10, p);
    check("R9 before", cur_count, 10);
    wr(2, 'h20010);
    check("R9 after ctl", cur_count, 10);
    run(2, 8'h10, p);
    check("R9 phase kept", cur_count, 9);

    // R10: idle tick enable holds the count
    repeat (10) @(negedge clk);
    check("R10 hold", cur_count, 9);

    finish_run();
  end
endmodule